// File: doc/BRIEF.md
# NOR Flash Program and Erase Engine

This block owns a byte-wide storage array and changes it the way a NOR flash cell array would. A program request writes one byte per cycle. By default the new byte is merged into the stored byte so that bits can only be cleared. When the rewrite-ones configuration input is set, the new byte replaces the stored byte outright, and the array then behaves like an EEPROM. An erase request names a start address and one of four erase kinds. The engine aligns the start address down, then fills the covered range with 0xFF, one byte per clock, and holds `busy` high while it does so.

Erasing needs the write-enable latch to be set. A refused erase produces a one-cycle error pulse. An erase kind that the configured device does not claim to support produces a one-cycle warning pulse, but the erase still runs. A sticky flag records any attempt to turn a 0 back into a 1 without rewrite-ones mode.

Reset is asynchronous and active low, and its release is synchronised inside the block. After reset the engine fills the whole physical array with 0xFF before it accepts any request, so the array starts blank. The array is read back through an asynchronous read port.

The address width and the two fixed erase sizes are parameters. The defaults are a 1024-byte array, a 64-byte small erase and a 256-byte mid erase. These scaled-down sizes stand in for the usual 4 KiB and 32 KiB erases.

Top module: `flash_pe_engine`

## Requirements
- R1: With `cfg_rewrite_ones` low, an accepted program leaves the stored byte equal to the old stored byte AND `prog_data`, readable at `rd_data` right after the accepting clock edge.
- R2: With `cfg_rewrite_ones` high, an accepted program leaves the stored byte equal to `prog_data`.
- R3: The erase length depends on `erase_kind`. Code 0 covers 2^SMALL_LOG2 bytes and code 1 covers 2^MID_LOG2 bytes. Code 2 covers 2^`cfg_sector_log2` bytes. Code 3 covers 2^`cfg_mem_log2` bytes and always starts at address 0.
- R4: An accepted erase sets every byte from the start address, aligned down to the erase length, through the end of that length to 0xFF. Bytes outside that range are unchanged.
- R5: An erase requested while `wr_en` is low is refused. `err_refused` is high for exactly the one cycle after the request, `busy` stays low, and the array is unchanged.
- R6: A code-0 erase with `cfg_cap_small` low, or a code-1 erase with `cfg_cap_mid` low, drives `warn_unsupported` high for the one cycle after the request. The erase still proceeds. Other erase kinds never warn.
- R7: After an accepted erase, `busy` is high for exactly as many cycles as the erase length, starting with the cycle after acceptance. Program and erase requests presented while `busy` is high are ignored.
- R8: After reset, `busy` is high until all 2^ADDR_W bytes read 0xFF.
- R9: A program with `cfg_rewrite_ones` low whose data has a 1 where the stored byte has a 0 sets `stuck_zero`. The flag stays set until reset.
- R10: When an erase and a program are requested in the same idle cycle, the erase is taken and the program is dropped.
- R11: A program is applied whatever the value of `wr_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_valid | input | 1 | Program request for one byte |
| prog_addr | input | ADDR_W | Program byte address |
| prog_data | input | 8 | Program data |
| erase_valid | input | 1 | Erase request |
| erase_addr | input | ADDR_W | Erase start address (aligned down internally) |
| erase_kind | input | 2 | 0 small, 1 mid, 2 main sector, 3 whole array |
| wr_en | input | 1 | Write-enable latch value |
| cfg_mem_log2 | input | LOG_W | log2 of the device size in bytes |
| cfg_sector_log2 | input | LOG_W | log2 of the main sector size |
| cfg_cap_small | input | 1 | Device claims the small erase |
| cfg_cap_mid | input | 1 | Device claims the mid erase |
| cfg_rewrite_ones | input | 1 | Program overwrites instead of clearing |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Stored byte at rd_addr (combinational) |
| busy | output | 1 | Erase fill in progress |
| err_refused | output | 1 | One-cycle pulse: erase refused |
| warn_unsupported | output | 1 | One-cycle pulse: erase kind not claimed by device |
| stuck_zero | output | 1 | Sticky: attempt to program 0 to 1 |

## Verification
Most wrong internal states in this block end up in the array contents. A bad fill pointer or a wrong alignment mask leaves bytes just inside or just outside the erase boundary with the wrong value, and a stale program merge leaves a wrong stored byte. Each of these shows at `rd_data` as soon as that address is read. The reference model is compared against `rd_data` every cycle, and the bench also probes the bytes on either side of each range.

A fill counter that is off by one changes the length of the `busy` window by a cycle, and that shows within the erase itself. A lost refusal or a lost capability decision shows on the pulse outputs in the single cycle after the request.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;
  typedef enum logic [1:0] {
    ERK_SMALL  = 2'd0,
    ERK_MID    = 2'd1,
    ERK_SECTOR = 2'd2,
    ERK_WHOLE  = 2'd3
  } erase_kind_e;
endpackage

// File: rtl/flash_pe_array.sv
module flash_pe_array #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr_a,
  output logic [7:0]        rdata_a,
  input  logic [ADDR_W-1:0] raddr_b,
  output logic [7:0]        rdata_b
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      cells[waddr] <= wdata;
    end
  end

  assign rdata_a = cells[raddr_a];
  assign rdata_b = cells[raddr_b];
endmodule

// File: rtl/flash_pe_prog.sv
module flash_pe_prog #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data,
  input  logic [7:0]        old_byte,
  input  logic              rewrite_ones,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic [7:0]        wdata,
  output logic              stuck
);
  logic stuck_q, stuck_d;
  logic raise;

  assign raise = req && !rewrite_ones && ((data & ~old_byte) != 8'h00);

  always_comb begin
    we    = req;
    waddr = addr;
    wdata = rewrite_ones ? data : (old_byte & data);
  end

  always_comb begin
    stuck_d = stuck_q;
    if (raise) begin
      stuck_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stuck_q <= 1'b0;
    end else if (raise) begin
      stuck_q <= stuck_d;
    end
  end

  assign stuck = stuck_q;

  AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    stuck_q |=> stuck_q); // R9
endmodule

// File: rtl/flash_pe_erase_ctrl.sv
module flash_pe_erase_ctrl
  import flash_pe_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int LOG_W      = 4,
  parameter int SMALL_LOG2 = 6,
  parameter int MID_LOG2   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] req_addr,
  input  erase_kind_e       req_kind,
  input  logic              wr_en,
  input  logic [LOG_W-1:0]  cfg_mem_log2,
  input  logic [LOG_W-1:0]  cfg_sector_log2,
  input  logic              cfg_cap_small,
  input  logic              cfg_cap_mid,
  output logic              busy,
  output logic              fill_we,
  output logic [ADDR_W-1:0] fill_addr,
  output logic              err,
  output logic              warn
);
  localparam logic [LOG_W-1:0] SMALL_LG = LOG_W'(SMALL_LOG2);
  localparam logic [LOG_W-1:0] MID_LG   = LOG_W'(MID_LOG2);

  logic              busy_q, busy_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [ADDR_W-1:0] last_q, last_d;
  logic              err_q, err_d;
  logic              warn_q, warn_d;
  logic [LOG_W-1:0]  len_lg;
  logic [ADDR_W-1:0] len_mask;
  logic [ADDR_W-1:0] base;

  function automatic logic [ADDR_W-1:0] low_mask(input logic [LOG_W-1:0] lg);
    logic [ADDR_W-1:0] m;
    for (int i = 0; i < ADDR_W; i++) begin
      m[i] = (i < int'(lg));
    end
    return m;
  endfunction

  always_comb begin
    unique case (req_kind)
      ERK_SMALL:  len_lg = SMALL_LG;
      ERK_MID:    len_lg = MID_LG;
      ERK_SECTOR: len_lg = cfg_sector_log2;
      default:    len_lg = cfg_mem_log2;
    endcase
    len_mask = low_mask(len_lg);
    base     = (req_kind == ERK_WHOLE) ? '0 : (req_addr & ~len_mask);
  end

  always_comb begin
    busy_d = busy_q;
    ptr_d  = ptr_q;
    last_d = last_q;
    err_d  = 1'b0;
    warn_d = 1'b0;
    if (busy_q) begin
      if (ptr_q == last_q) begin
        busy_d = 1'b0;
      end else begin
        ptr_d = ptr_q + ADDR_W'(1);
      end
    end else if (req) begin
      warn_d = ((req_kind == ERK_SMALL) && !cfg_cap_small) ||
               ((req_kind == ERK_MID) && !cfg_cap_mid);
      if (!wr_en) begin
        err_d = 1'b1;
      end else begin
        busy_d = 1'b1;
        ptr_d  = base;
        last_d = base | len_mask;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b1;
      ptr_q  <= '0;
      last_q <= '1;
      err_q  <= 1'b0;
      warn_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      err_q  <= err_d;
      warn_q <= warn_d;
      if (busy_q || req) begin
        ptr_q  <= ptr_d;
        last_q <= last_d;
      end
    end
  end

  assign busy      = busy_q;
  assign fill_we   = busy_q;
  assign fill_addr = ptr_q;
  assign err       = err_q;
  assign warn      = warn_q;

  AST_FILL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (ptr_q <= last_q)); // R3
  AST_BUSY_ENDS_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(ptr_q) == $past(last_q))); // R7
  AST_REFUSE_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> !busy_q); // R5
endmodule

// File: rtl/flash_pe_engine.sv
module flash_pe_engine
  import flash_pe_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int SMALL_LOG2 = 6,
  parameter int MID_LOG2   = 8,
  parameter int LOG_W      = $clog2(ADDR_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_valid,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [7:0]        prog_data,
  input  logic              erase_valid,
  input  logic [ADDR_W-1:0] erase_addr,
  input  logic [1:0]        erase_kind,
  input  logic              wr_en,
  input  logic [LOG_W-1:0]  cfg_mem_log2,
  input  logic [LOG_W-1:0]  cfg_sector_log2,
  input  logic              cfg_cap_small,
  input  logic              cfg_cap_mid,
  input  logic              cfg_rewrite_ones,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              busy,
  output logic              err_refused,
  output logic              warn_unsupported,
  output logic              stuck_zero
);
  logic              rst_meta, rst_s;
  logic              eng_busy;
  logic              erase_take, prog_take;
  logic              fill_we;
  logic [ADDR_W-1:0] fill_addr;
  logic              pg_we;
  logic [ADDR_W-1:0] pg_waddr;
  logic [7:0]        pg_wdata;
  logic [7:0]        old_byte;
  logic              arr_we;
  logic [ADDR_W-1:0] arr_waddr;
  logic [7:0]        arr_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  assign erase_take = erase_valid && !eng_busy;
  assign prog_take  = prog_valid && !erase_valid && !eng_busy;

  flash_pe_erase_ctrl #(
    .ADDR_W(ADDR_W), .LOG_W(LOG_W),
    .SMALL_LOG2(SMALL_LOG2), .MID_LOG2(MID_LOG2)
  ) u_erase (
    .clk(clk), .rst_n(rst_s),
    .req(erase_take), .req_addr(erase_addr),
    .req_kind(erase_kind_e'(erase_kind)), .wr_en(wr_en),
    .cfg_mem_log2(cfg_mem_log2), .cfg_sector_log2(cfg_sector_log2),
    .cfg_cap_small(cfg_cap_small), .cfg_cap_mid(cfg_cap_mid),
    .busy(eng_busy), .fill_we(fill_we), .fill_addr(fill_addr),
    .err(err_refused), .warn(warn_unsupported)
  );

  flash_pe_prog #(.ADDR_W(ADDR_W)) u_prog (
    .clk(clk), .rst_n(rst_s),
    .req(prog_take), .addr(prog_addr), .data(prog_data),
    .old_byte(old_byte), .rewrite_ones(cfg_rewrite_ones),
    .we(pg_we), .waddr(pg_waddr), .wdata(pg_wdata), .stuck(stuck_zero)
  );

  always_comb begin
    if (fill_we) begin
      arr_we    = 1'b1;
      arr_waddr = fill_addr;
      arr_wdata = 8'hFF;
    end else begin
      arr_we    = pg_we;
      arr_waddr = pg_waddr;
      arr_wdata = pg_wdata;
    end
  end

  flash_pe_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata),
    .raddr_a(rd_addr), .rdata_a(rd_data),
    .raddr_b(prog_addr), .rdata_b(old_byte)
  );

  assign busy = eng_busy;

  AST_ERASE_WRITES_ONES: assert property (@(posedge clk) disable iff (!rst_s)
    (eng_busy && arr_we) |-> (arr_wdata == 8'hFF)); // R4
  AST_NO_PROG_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_s)
    eng_busy |-> !pg_we); // R7
endmodule

// File: tb/flash_pe_engine_bench.sv
module flash_pe_engine_bench;
  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n;
  logic prog_valid, erase_valid, wr_en;
  logic [AW-1:0] prog_addr, erase_addr, rd_addr;
  logic [7:0] prog_data, rd_data;
  logic [1:0] erase_kind;
  logic [3:0] cfg_mem_log2, cfg_sector_log2;
  logic cfg_cap_small, cfg_cap_mid, cfg_rewrite_ones;
  logic busy, err_refused, warn_unsupported, stuck_zero;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  flash_pe_engine u_flash_pe_engine (
    .clk(clk), .rst_n(rst_n),
    .prog_valid(prog_valid), .prog_addr(prog_addr), .prog_data(prog_data),
    .erase_valid(erase_valid), .erase_addr(erase_addr), .erase_kind(erase_kind),
    .wr_en(wr_en), .cfg_mem_log2(cfg_mem_log2), .cfg_sector_log2(cfg_sector_log2),
    .cfg_cap_small(cfg_cap_small), .cfg_cap_mid(cfg_cap_mid),
    .cfg_rewrite_ones(cfg_rewrite_ones),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
    .err_refused(err_refused), .warn_unsupported(warn_unsupported),
    .stuck_zero(stuck_zero)
  );

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // behavioural reference model
  logic [7:0] mm [DEPTH];
  bit model_on = 0;
  bit m_busy, m_err, m_warn, m_sticky;
  int m_ptr, m_last, m_len;

  always @(posedge clk) begin
    if (model_on) begin
      m_err = 0;
      m_warn = 0;
      if (m_busy) begin
        mm[m_ptr] = 8'hFF;
        if (m_ptr == m_last) m_busy = 0;
        else m_ptr++;
      end else if (erase_valid) begin
        case (erase_kind)
          2'd0: m_len = 64;
          2'd1: m_len = 256;
          2'd2: m_len = 1 << cfg_sector_log2;
          default: m_len = 1 << cfg_mem_log2;
        endcase
        m_warn = (erase_kind == 2'd0 && !cfg_cap_small) || (erase_kind == 2'd1 && !cfg_cap_mid);
        if (!wr_en) m_err = 1;
        else begin
          m_busy = 1;
          m_ptr = (erase_kind == 2'd3) ? 0 : (int'(erase_addr) / m_len) * m_len;
          m_last = m_ptr + m_len - 1;
        end
      end else if (prog_valid) begin
        if (!cfg_rewrite_ones && ((prog_data & ~mm[prog_addr]) != 0)) m_sticky = 1;
        mm[prog_addr] = cfg_rewrite_ones ? prog_data : (mm[prog_addr] & prog_data);
      end
    end
  end

  always @(negedge clk) begin
    #1;
    if (model_on) begin
      check("R7 busy vs model", busy, m_busy);
      check("R5 err vs model", err_refused, m_err);
      check("R6 warn vs model", warn_unsupported, m_warn);
      check("R9 sticky vs model", stuck_zero, m_sticky);
      check("R1 R2 R4 data vs model", rd_data, mm[rd_addr]);
    end
  end

  task automatic peek(input int a, output int v);
    @(negedge clk);
    rd_addr = AW'(a);
    #2;
    v = rd_data;
  endtask

  task automatic prog(input int a, input int d);
    @(negedge clk);
    prog_valid = 1; prog_addr = AW'(a); prog_data = 8'(d);
    @(negedge clk);
    prog_valid = 0;
  endtask

  task automatic do_erase(input int kind, input int a, input bit with_prog,
                          input int pa, output int e, output int w, output int bc);
    @(negedge clk);
    erase_valid = 1; erase_kind = 2'(kind); erase_addr = AW'(a);
    prog_valid = with_prog; prog_addr = AW'(pa); prog_data = 8'h00;
    @(negedge clk);
    erase_valid = 0; prog_valid = 0;
    #1;
    e = err_refused; w = warn_unsupported; bc = 0;
    while (busy) begin
      bc++;
      if (bc == 3) begin
        // request during the fill: must be ignored (R7)
        prog_valid = 1; prog_addr = AW'(10'h390); prog_data = 8'h00;
        erase_valid = 1; erase_kind = 2'd3;
      end
      @(negedge clk);
      prog_valid = 0; erase_valid = 0;
      #1;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int v, e, w, bc, nbad, cyc;
    rst_n = 0;
    prog_valid = 0; erase_valid = 0; wr_en = 0;
    prog_addr = '0; prog_data = '0; erase_addr = '0; erase_kind = '0; rd_addr = '0;
    cfg_mem_log2 = 4'd10; cfg_sector_log2 = 4'd7;
    cfg_cap_small = 1; cfg_cap_mid = 1; cfg_rewrite_ones = 0;
    repeat (3) @(negedge clk);
    #1;
    check("R8 busy during reset", busy, 1);
    check("R8 sticky clear at reset", stuck_zero, 0);
    rst_n = 1;
    cyc = 0;
    while (busy && cyc < 2000) begin @(negedge clk); #1; cyc++; end
    check("R8 init fill length at least array size", int'(cyc >= DEPTH), 1);
    check("R8 init fill ends", busy, 0);
    nbad = 0;
    for (int a = 0; a < DEPTH; a++) begin peek(a, v); if (v != 8'hFF) nbad++; end
    check("R8 array blank after reset", nbad, 0);
    for (int a = 0; a < DEPTH; a++) mm[a] = 8'hFF;
    m_busy = 0; m_err = 0; m_warn = 0; m_sticky = 0;
    model_on = 1;

    // R1: AND merge, R9 stays clear while only clearing bits
    prog(5, 8'h0F); peek(5, v); check("R1 first program", v, 8'h0F);
    prog(5, 8'h03); peek(5, v); check("R1 second program", v, 8'h03);
    check("R9 no flag on clearing", stuck_zero, 0);
    prog(5, 8'hF0); peek(5, v); check("R1 zero to one blocked", v, 8'h00);
    check("R9 flag set", stuck_zero, 1);

    // R2 / R11: rewrite-ones mode with wr_en low
    cfg_rewrite_ones = 1;
    prog(6, 8'h00); prog(6, 8'h3C); peek(6, v);
    check("R2 R11 overwrite with wr_en low", v, 8'h3C);
    cfg_rewrite_ones = 0;

    // R5: refused erase
    do_erase(0, 5, 0, 0, e, w, bc);
    check("R5 err pulse", e, 1);
    check("R5 no busy", bc, 0);
    peek(5, v); check("R5 array unchanged", v, 8'h00);

    // R4 R6 R7: small erase, unsupported, aligned down
    wr_en = 1; cfg_cap_small = 0;
    prog(10'h40, 8'h11); prog(10'h7F, 8'h22); prog(10'h80, 8'h33); prog(10'h3F, 8'h44);
    do_erase(0, 10'h45, 0, 0, e, w, bc);
    check("R6 warn pulse small", w, 1);
    check("R5 no err when enabled", e, 0);
    check("R3 R7 small busy length", bc, 64);
    peek(10'h40, v); check("R4 first byte erased", v, 8'hFF);
    peek(10'h7F, v); check("R4 last byte erased", v, 8'hFF);
    peek(10'h80, v); check("R4 byte above kept", v, 8'h33);
    peek(10'h3F, v); check("R4 byte below kept", v, 8'h44);
    peek(10'h390, v); check("R7 program during busy ignored", v, 8'hFF);
    cfg_cap_small = 1;

    // R10: mid erase with simultaneous program
    prog(10'h1A0, 8'h01);
    do_erase(1, 10'h1A0, 1, 10'h300, e, w, bc);
    check("R6 no warn when supported", w, 0);
    check("R3 mid busy length", bc, 256);
    peek(10'h300, v); check("R10 program dropped", v, 8'hFF);
    peek(10'h1A0, v); check("R4 mid erased", v, 8'hFF);

    // R3: sector erase
    prog(10'h27F, 8'h55); prog(10'h280, 8'h66);
    do_erase(2, 10'h2C0, 0, 0, e, w, bc);
    check("R3 sector busy length", bc, 128);
    peek(10'h280, v); check("R3 sector start erased", v, 8'hFF);
    peek(10'h27F, v); check("R3 below sector kept", v, 8'h55);

    // R3: whole erase from 0 with 512-byte device
    cfg_mem_log2 = 4'd9;
    prog(10'h1FF, 8'h12); prog(10'h200, 8'h34); prog(5, 8'h00);
    do_erase(3, 10'h250, 0, 0, e, w, bc);
    check("R3 whole busy length", bc, 512);
    peek(5, v); check("R3 whole starts at 0", v, 8'hFF);
    peek(10'h1FF, v); check("R3 whole last byte", v, 8'hFF);
    peek(10'h200, v); check("R3 beyond device kept", v, 8'h34);
    check("R9 flag still set", stuck_zero, 1);

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule